// File: doc/BRIEF.md
# Three-Phase Processor Clock Divider

This block derives a processor clock and a peripheral clock from one fast source clock that already runs at three times the processor rate. The processor clock is high for one source cycle out of every three. The peripheral clock toggles on each rising edge of the processor clock, so it runs at half that rate with equal high and low times. A synchronous alignment clear stops the divider. Several such dividers that share a source clock can release the clear on the same edge and then run in phase. The clear must already be synchronous to the source clock.

Neighbouring logic stays in the fast clock domain. Two one-cycle strobes announce the next rising and the next falling edge of the processor clock. An active-low reset request is captured into an active-high system reset only at falling edges of the processor clock. An oscillator input is passed straight through to an output, and this pass-through is independent of the divider.

The divider is a state machine with four states: HOLD, HIGH, LOW1 and LOW2. The transitions are HOLD→HIGH, HIGH→LOW1, LOW1→LOW2 and LOW2→HIGH, each taken when the clear is low. Any state moves to HOLD when the clear is high.

Top module: `tri_phase_clkgen`

## Requirements
- R1: While `rst_n` is low, `cpu_clk` and `per_clk` are 0, `sys_reset` is 1, and the divider sits in HOLD. In HOLD with `align_clr` low, `cpu_rise_stb` is 1.
- R2: With `align_clr` low, `cpu_clk` repeats a 3-cycle pattern of one high cycle and two low cycles. Its first high cycle is the first source cycle after leaving HOLD.
- R3: `per_clk` inverts on every rising edge of `cpu_clk` and holds its value otherwise. After the clear is released it repeats three cycles high and three cycles low, starting high.
- R4: While `align_clr` is high, `cpu_clk` and `per_clk` are 0 from the next edge on and the phase does not advance. After a release, `cpu_clk` rises on the first edge.
- R5: `cpu_rise_stb` is 1 exactly in the cycles whose closing edge raises `cpu_clk`.
- R6: `cpu_fall_stb` is 1 exactly in the cycles where `cpu_clk` is high, that is, the cycles whose closing edge lowers it.
- R7: `sys_reset` loads the inverse of `rst_req_n` only on an edge where `cpu_clk` falls. It is unchanged on every other edge, including all edges while the clear is held.
- R8: `osc_out` always equals `osc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock, three times the processor rate |
| rst_n | input | 1 | Asynchronous active-low block reset |
| align_clr | input | 1 | Synchronous clear that holds the divider for phase alignment |
| rst_req_n | input | 1 | Active-low system reset request |
| osc_in | input | 1 | Oscillator clock to pass through |
| cpu_clk | output | 1 | Processor clock, one-third duty |
| per_clk | output | 1 | Peripheral clock, half of `cpu_clk`, 50% duty |
| cpu_rise_stb | output | 1 | High in the cycle before `cpu_clk` rises |
| cpu_fall_stb | output | 1 | High in the cycle before `cpu_clk` falls |
| sys_reset | output | 1 | Active-high system reset, changes on `cpu_clk` falls |
| osc_out | output | 1 | Copy of `osc_in` |

## Verification
The assertions check the following on every cycle:
- A high `cpu_clk` cycle is always followed by a low one.
- The clear forces both clocks low.
- Each strobe is followed by its promised edge, and each edge was preceded by its strobe.
- `per_clk` inverts on every `cpu_clk` rise.
- `sys_reset` stays stable unless the previous cycle carried a fall strobe.

Only the bench scenarios can show the rest: the exact three-cycle phase after a release, the six-cycle peripheral period, and that the value loaded into `sys_reset` is the request level at the falling edge. These scenarios sweep clear pulses of several lengths and reset request changes across every phase offset.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    // Divider phase states; HOLD is entered whenever the alignment clear is high
    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW1 = 2'd2,
        PH_LOW2 = 2'd3
    } phase_e;

    localparam int unsigned DIV_RATIO = 3;
    localparam logic SYS_RESET_INIT = 1'b1;
endpackage

// File: rtl/tpc_phase_fsm.sv
module tpc_phase_fsm
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic align_clr,
    output logic cpu_clk_o,
    output logic rise_stb_o,
    output logic fall_stb_o
);
    phase_e state_q;
    phase_e state_d;
    logic   cpu_clk_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (align_clr) begin
            state_d = PH_HOLD;
        end else begin
            unique case (state_q)
                PH_HOLD: state_d = PH_HIGH;
                PH_HIGH: state_d = PH_LOW1;
                PH_LOW1: state_d = PH_LOW2;
                PH_LOW2: state_d = PH_HIGH;
                default: state_d = PH_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // registered clock output, glitch free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_clk_q <= 1'b0;
        end else begin
            cpu_clk_q <= (state_d == PH_HIGH);
        end
    end

    // edge strobes: announce what the closing edge of this cycle does
    always_comb begin
        rise_stb_o = 1'b0;
        fall_stb_o = 1'b0;
        unique case (state_q)
            PH_HOLD: rise_stb_o = !align_clr;
            PH_HIGH: fall_stb_o = 1'b1;
            PH_LOW1: rise_stb_o = 1'b0;
            PH_LOW2: rise_stb_o = !align_clr;
            default: rise_stb_o = 1'b0;
        endcase
    end

    assign cpu_clk_o = cpu_clk_q;
endmodule

// File: rtl/tpc_per_div.sv
module tpc_per_div (
    input  logic clk,
    input  logic rst_n,
    input  logic align_clr,
    input  logic rise_stb,
    output logic per_clk_o
);
    logic per_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= 1'b0;
        end else if (align_clr) begin
            per_q <= 1'b0;
        end else if (rise_stb) begin
            per_q <= ~per_q;
        end
    end

    assign per_clk_o = per_q;
endmodule

// File: rtl/tpc_rst_capture.sv
module tpc_rst_capture #(
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_stb,
    input  logic rst_req_n,
    output logic sys_reset_o
);
    logic rst_q;

    // sampled only on the fast edge that lowers the processor clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q <= INIT;
        end else if (fall_stb) begin
            rst_q <= ~rst_req_n;
        end
    end

    assign sys_reset_o = rst_q;
endmodule

// File: rtl/tri_phase_clkgen.sv
module tri_phase_clkgen
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic align_clr,
    input  logic rst_req_n,
    input  logic osc_in,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_rise_stb,
    output logic cpu_fall_stb,
    output logic sys_reset,
    output logic osc_out
);
    logic rise_s;
    logic fall_s;

    tpc_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .align_clr  (align_clr),
        .cpu_clk_o  (cpu_clk),
        .rise_stb_o (rise_s),
        .fall_stb_o (fall_s)
    );

    tpc_per_div u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .align_clr (align_clr),
        .rise_stb  (rise_s),
        .per_clk_o (per_clk)
    );

    tpc_rst_capture #(.INIT(SYS_RESET_INIT)) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_stb    (fall_s),
        .rst_req_n   (rst_req_n),
        .sys_reset_o (sys_reset)
    );

    assign cpu_rise_stb = rise_s;
    assign cpu_fall_stb = fall_s;
    assign osc_out      = osc_in;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker (
    input logic clk,
    input logic rst_n,
    input logic align_clr,
    input logic cpu_clk,
    input logic per_clk,
    input logic cpu_rise_stb,
    input logic cpu_fall_stb,
    input logic sys_reset
);
    assert_high_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk |=> !cpu_clk);

    assert_clear_forces_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        align_clr |=> (!cpu_clk && !per_clk));

    assert_rise_follows_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rise_stb |=> cpu_clk);

    assert_rise_had_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk) |-> $past(cpu_rise_stb));

    assert_fall_follows_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fall_stb |=> !cpu_clk);

    assert_fall_had_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk) |-> $past(cpu_fall_stb));

    assert_per_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk) |-> (per_clk != $past(per_clk)));

    assert_reset_only_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_fall_stb) |-> $stable(sys_reset));
endmodule

bind tri_phase_clkgen tpc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .align_clr    (align_clr),
    .cpu_clk      (cpu_clk),
    .per_clk      (per_clk),
    .cpu_rise_stb (cpu_rise_stb),
    .cpu_fall_stb (cpu_fall_stb),
    .sys_reset    (sys_reset)
);

// File: tb/tri_phase_clkgen_bench.sv
`timescale 1ns/1ps
module tri_phase_clkgen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic rreq = 1'b1;
    logic osc = 1'b0;
    logic cpu_clk, per_clk, rise_stb, fall_stb, sys_reset, osc_out;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    logic ecpu = 1'b0;
    logic eper = 1'b0;
    logic erst = 1'b1;
    logic [7:0] lfsr = 8'hA5;
    bit done = 0;

    always #2.5 clk = ~clk;

    tri_phase_clkgen u_tri_phase_clkgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .align_clr    (clr),
        .rst_req_n    (rreq),
        .osc_in       (osc),
        .cpu_clk      (cpu_clk),
        .per_clk      (per_clk),
        .cpu_rise_stb (rise_stb),
        .cpu_fall_stb (fall_stb),
        .sys_reset    (sys_reset),
        .osc_out      (osc_out)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b cnt=%0d t=%0t", req, what, act, exp, cnt, $time);
        end
    endtask

    task automatic check_all();
        logic erise;
        erise = !clr && (cnt == 0 || ((cnt - 1) % 3) == 2);
        chk("R2", "cpu_clk", cpu_clk, ecpu);
        chk("R3", "per_clk", per_clk, eper);
        chk("R5", "rise_stb", rise_stb, erise);
        chk("R6", "fall_stb", fall_stb, ecpu);
        chk("R7", "sys_reset", sys_reset, erst);
        chk("R8", "osc_out", osc_out, osc);
    endtask

    // one source cycle: model update at the edge, check mid-cycle
    task automatic step();
        logic prev;
        @(posedge clk);
        if (clr) cnt = 0; else cnt++;
        prev = ecpu;
        ecpu = (cnt > 0) && (((cnt - 1) % 3) == 0);
        eper = (cnt > 0) && ((((cnt - 1) / 3) % 2) == 0);
        if (prev && !ecpu) erst = !rreq;
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        osc = lfsr[0];
        @(negedge clk);
        check_all();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic held;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cpu_clk in reset", cpu_clk, 1'b0);
        chk("R1", "per_clk in reset", per_clk, 1'b0);
        chk("R1", "sys_reset in reset", sys_reset, 1'b1);
        chk("R1", "rise_stb in HOLD", rise_stb, 1'b1);
        rst_n = 1'b1;

        // R2 R3 R5 R6: free running
        run(30);

        // R7: request changes at every phase offset
        for (int off = 0; off < 6; off++) begin
            run(off);
            rreq = 1'b0;
            run(8);
            rreq = 1'b1;
            run(7);
        end

        // R4: clear pulses of several lengths at each phase
        for (int off = 0; off < 3; off++) begin
            for (int len = 1; len <= 4; len++) begin
                run(off);
                clr = 1'b1;
                run(len);
                clr = 1'b0;
                run(10);
            end
        end

        // R4: after release, first edge raises cpu_clk
        clr = 1'b1;
        run(3);
        clr = 1'b0;
        step();
        chk("R4", "cpu_clk first edge after release", cpu_clk, 1'b1);

        // R7: request change during clear has no effect
        clr = 1'b1;
        run(2);
        held = sys_reset;
        rreq = ~rreq;
        run(6);
        chk("R7", "sys_reset stable while clear held", sys_reset, held);
        clr = 1'b0;
        run(12);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule